// File: doc/BRIEF.md
# MII receive frame status checker

This block watches a 4-bit MII receive path, one nibble per clock, and builds a 16-bit status word for every receive event. It follows the frame from its first valid nibble. It checks the preamble and the start delimiter, and drops the frame when the preamble is impure or too long and the matching check is enabled. It counts nibbles and runs a CRC-32 over everything after the delimiter. It decodes the destination address class and the length/type field, and marks frames with coding errors, alignment errors or excessive length.

When the data-valid input falls, the collected word goes out on `status_o` with a single-cycle `done_o` strobe. The word then holds until the next frame ends. Downstream logic uses the word to accept the frame or to count the fault. Nibbles arrive low nibble first, so each byte is assembled from two consecutive nibbles.

Top module: `mii_rx_status`

## Requirements
- R1: `done_o` pulses for exactly one cycle, on the cycle after the first sampled cycle with `rx_dv_i` low following a frame. `status_o` changes only together with `done_o`. Both are zero after reset.
- R2: Nibbles before the first 4'hD are preamble. With `pure_pre_en_i` high, any preamble nibble other than 4'h5 drops the frame. A dropped frame reports bit 12 plus only bits 2 and 3 as collected. With the check off, such a frame is processed normally.
- R3: With `long_pre_en_i` high, a frame with more than 23 nibbles before 4'hD (more than 11 preamble bytes) is dropped in the same way as in R2. At 23 nibbles, or with the check off, the frame is processed normally.
- R4: Bit 12 is set when `rx_dv_i` stays high for more than `LONG_NIBBLES` cycles (default 12500 nibbles, 50,000 bit times).
- R5: The CRC-32 (reflected polynomial 0xEDB88320, preset all ones, no final inversion) runs over all nibbles after 4'hD, bit 0 first. Bit 13 is set when the final register differs from 0xDEBB20E3.
- R6: Bit 14 is set when an odd number of nibbles follows 4'hD.
- R7: Bit 2 reports a carrier event: `rx_er_i`=1, `rx_dv_i`=0 and `rxd_i`=4'hE, seen since the previous frame ended. Bit 3 is set when `rx_er_i` is high in any cycle with `rx_dv_i` high.
- R8: Bit 1 is set on a non-dropped frame that has no 4'hD, or that has fewer than 128 nibbles after 4'hD.
- R9: Bytes 12 and 13 after the delimiter form a big-endian length/type field. A value of 1518 or less is a length: bit 4 is set when it differs from the total byte count minus 18. A value from 1519 to 1535 sets bit 5.
- R10: Bit 8 is set when the six destination bytes are all 8'hFF. Bit 9 is set when bit 0 of byte 0 is 1 and the frame is not broadcast.
- R11: Type 0x8100 sets bit 7. Type 0x8808 sets bit 10. For such a frame, opcode bytes 14–15 equal to 0x0001 set bit 11, and any other opcode sets bit 6.
- R12: Bit 0 is always 0. Bit 15 is set exactly when none of bits 0–5 and 12–14 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble-rate receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 4 | Receive nibble, low nibble of each byte first |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error from the PHY |
| pure_pre_en_i | input | 1 | Drop frames with an impure preamble |
| long_pre_en_i | input | 1 | Drop frames with a preamble over 11 bytes |
| status_o | output | 16 | Status word of the last completed frame |
| done_o | output | 1 | One-cycle strobe when `status_o` is updated |

## Verification
Two decisions fall on the same delimiter nibble: detecting the start of data and rejecting a long preamble. Preamble lengths of 1 to 26 nibbles are swept with rejection on and off, and the bench expects a clean frame or a bit-12 drop at the 23/24 boundary. A coding error on the final data nibble lands one cycle before the frame end, so it must appear in the word reported for that same frame. The bench places `rx_er_i` there and checks bit 3 together with the still-valid CRC and length results.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_DROP} rx_state_e;

  localparam int B_OVR     = 0;
  localparam int B_SHORT   = 1;
  localparam int B_CARRIER = 2;
  localparam int B_CODEV   = 3;
  localparam int B_LENERR  = 4;
  localparam int B_OOR     = 5;
  localparam int B_OPCODE  = 6;
  localparam int B_VLAN    = 7;
  localparam int B_BCAST   = 8;
  localparam int B_MCAST   = 9;
  localparam int B_CTRL    = 10;
  localparam int B_PAUSE   = 11;
  localparam int B_LONG    = 12;
  localparam int B_CRC     = 13;
  localparam int B_ALIGN   = 14;
  localparam int B_OK      = 15;

  localparam logic [15:0] ERR_MASK    = 16'h703F;
  localparam logic [3:0]  PRE_NIB     = 4'h5;
  localparam logic [3:0]  SFD_NIB     = 4'hD;
  localparam logic [3:0]  CARRIER_NIB = 4'hE;
  localparam logic [15:0] LEN_MAX     = 16'd1518;
  localparam logic [15:0] TYPE_MIN    = 16'h0600;
  localparam logic [15:0] TYPE_VLAN   = 16'h8100;
  localparam logic [15:0] TYPE_CTRL   = 16'h8808;
  localparam logic [15:0] OP_PAUSE    = 16'h0001;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
endpackage

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
  import mii_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [3:0]  nib_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    for (int k = 0; k < 4; k++) begin
      crc_d = (crc_d[0] ^ nib_i[k]) ? ((crc_d >> 1) ^ CRC_POLY) : (crc_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mii_rx_fields.sv
module mii_rx_fields #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [3:0]       nib_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic             bcast_o,
  output logic             mcast_o,
  output logic [15:0]      type_o,
  output logic [15:0]      op_o
);
  localparam int BI_W = CNT_W - 1;

  logic [3:0]      lo_q;
  logic [7:0]      byte_w;
  logic [BI_W-1:0] bidx;
  logic            bcast_q, mcast_q;
  logic [15:0]     type_q, op_q;

  assign byte_w = {nib_i, lo_q};
  assign bidx   = idx_i[CNT_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0; bcast_q <= 1'b1; mcast_q <= 1'b0; type_q <= '0; op_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0; bcast_q <= 1'b1; mcast_q <= 1'b0; type_q <= '0; op_q <= '0;
    end else if (en_i) begin
      if (!idx_i[0]) begin
        lo_q <= nib_i;
      end else begin
        if (bidx < BI_W'(6))  bcast_q <= bcast_q & (byte_w == 8'hFF);
        if (bidx == BI_W'(0)) mcast_q <= byte_w[0];
        if (bidx == BI_W'(12)) type_q[15:8] <= byte_w;
        if (bidx == BI_W'(13)) type_q[7:0]  <= byte_w;
        if (bidx == BI_W'(14)) op_q[15:8]   <= byte_w;
        if (bidx == BI_W'(15)) op_q[7:0]    <= byte_w;
      end
    end
  end

  assign bcast_o = bcast_q;
  assign mcast_o = mcast_q;
  assign type_o  = type_q;
  assign op_o    = op_q;
endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
  import mii_rx_pkg::*;
#(
  parameter int LONG_NIBBLES    = 12500,
  parameter int PRE_MAX_NIBBLES = 23,
  parameter int MIN_NIBBLES     = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  rxd_i,
  input  logic        rx_dv_i,
  input  logic        rx_er_i,
  input  logic        pure_pre_en_i,
  input  logic        long_pre_en_i,
  output logic [15:0] status_o,
  output logic        done_o
);
  localparam int CNT_W = $clog2(LONG_NIBBLES + 2);
  localparam int PRE_W = $clog2(PRE_MAX_NIBBLES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_NIBBLES + 1);
  localparam logic [PRE_W-1:0] PRE_SAT = PRE_W'(PRE_MAX_NIBBLES + 1);

  rx_state_e        state_q, state_d;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [CNT_W-1:0] tot_cnt_q, dat_cnt_q, nb;
  logic             carrier_q, cv_q;
  logic             in_pre, frame_end, sfd_hit, dat_nib, car_now;
  logic [31:0]      crc;
  logic             bcast, mcast;
  logic [15:0]      type_f, op_f;
  logic             got_sfd, has_dst, has_type, has_op, has_len, is_ctrl, is_pause;
  logic [15:0]      st_d, status_q;
  logic             done_q;

  assign in_pre    = (state_q == ST_IDLE) || (state_q == ST_PRE);
  assign frame_end = (state_q != ST_IDLE) && !rx_dv_i;
  assign sfd_hit   = in_pre && rx_dv_i && (rxd_i == SFD_NIB);
  assign dat_nib   = (state_q == ST_DATA) && rx_dv_i;
  assign car_now   = !rx_dv_i && rx_er_i && (rxd_i == CARRIER_NIB);

  always_comb begin
    state_d = state_q;
    if (in_pre && rx_dv_i) begin
      if (rxd_i == SFD_NIB)
        state_d = (long_pre_en_i && pre_cnt_q > PRE_W'(PRE_MAX_NIBBLES)) ? ST_DROP : ST_DATA;
      else if (pure_pre_en_i && rxd_i != PRE_NIB)
        state_d = ST_DROP;
      else
        state_d = ST_PRE;
    end else if (frame_end) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pre_cnt_q <= '0;
      tot_cnt_q <= '0;
      dat_cnt_q <= '0;
      carrier_q <= 1'b0;
      cv_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!rx_dv_i)                               pre_cnt_q <= '0;
      else if (in_pre && pre_cnt_q != PRE_SAT)    pre_cnt_q <= pre_cnt_q + 1'b1;
      if (!rx_dv_i)                               tot_cnt_q <= '0;
      else if (tot_cnt_q != CNT_SAT)              tot_cnt_q <= tot_cnt_q + 1'b1;
      if (sfd_hit)                                dat_cnt_q <= '0;
      else if (dat_nib && dat_cnt_q != CNT_SAT)   dat_cnt_q <= dat_cnt_q + 1'b1;
      // a carrier event in the frame-end cycle belongs to the next frame
      carrier_q <= frame_end ? car_now : (carrier_q | car_now);
      if (frame_end)                  cv_q <= 1'b0;
      else if (rx_dv_i && rx_er_i)    cv_q <= 1'b1;
    end
  end

  mii_rx_crc u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sfd_hit),
    .en_i  (dat_nib),
    .nib_i (rxd_i),
    .crc_o (crc)
  );

  mii_rx_fields #(.CNT_W(CNT_W)) u_fields (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sfd_hit),
    .en_i   (dat_nib),
    .nib_i  (rxd_i),
    .idx_i  (dat_cnt_q),
    .bcast_o(bcast),
    .mcast_o(mcast),
    .type_o (type_f),
    .op_o   (op_f)
  );

  always_comb begin
    nb       = dat_cnt_q >> 1;
    got_sfd  = (state_q == ST_DATA);
    has_dst  = got_sfd && nb >= CNT_W'(6);
    has_type = got_sfd && nb >= CNT_W'(14);
    has_op   = got_sfd && nb >= CNT_W'(16);
    has_len  = got_sfd && nb >= CNT_W'(18);
    is_ctrl  = has_type && type_f == TYPE_CTRL;
    is_pause = is_ctrl && has_op && op_f == OP_PAUSE;
    st_d = '0;
    st_d[B_OVR]     = 1'b0;
    st_d[B_SHORT]   = (state_q != ST_DROP) && (!got_sfd || dat_cnt_q < CNT_W'(MIN_NIBBLES));
    st_d[B_CARRIER] = carrier_q;
    st_d[B_CODEV]   = cv_q;
    st_d[B_LENERR]  = has_len && type_f <= LEN_MAX && (32'(type_f) != 32'(nb) - 32'd18);
    st_d[B_OOR]     = has_type && type_f > LEN_MAX && type_f < TYPE_MIN;
    st_d[B_OPCODE]  = is_ctrl && !is_pause;
    st_d[B_VLAN]    = has_type && type_f == TYPE_VLAN;
    st_d[B_BCAST]   = has_dst && bcast;
    st_d[B_MCAST]   = has_dst && mcast && !bcast;
    st_d[B_CTRL]    = is_ctrl;
    st_d[B_PAUSE]   = is_pause;
    st_d[B_LONG]    = (state_q == ST_DROP) || tot_cnt_q > CNT_W'(LONG_NIBBLES);
    st_d[B_CRC]     = got_sfd && crc != CRC_RESIDUE;
    st_d[B_ALIGN]   = got_sfd && dat_cnt_q[0];
    st_d[B_OK]      = (st_d & ERR_MASK) == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (frame_end) status_q <= st_d;
    end
  end

  assign status_o = status_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mii_rx_status_chk.sv
module mii_rx_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_dv_i,
  input logic [15:0] status_o,
  input logic        done_o
);
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_dv_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!rx_dv_i));

  assert_status_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(status_o));

  assert_bcast_mcast_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(status_o[8] && status_o[9]));

  assert_pause_is_ctrl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[11]) |-> (status_o[10] && !status_o[6]));

  assert_vlan_not_ctrl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(status_o[7] && status_o[10]));

  assert_ok_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[15]) |-> (status_o[14:12] == 3'b0 && status_o[5:0] == 6'b0));
endmodule

bind mii_rx_status mii_rx_status_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rx_dv_i (rx_dv_i),
  .status_o(status_o),
  .done_o  (done_o)
);

// File: tb/mii_rx_status_tb.sv
module mii_rx_status_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rxd_i = '0;
  logic        rx_dv_i = 1'b0;
  logic        rx_er_i = 1'b0;
  logic        pure_pre_en_i = 1'b0;
  logic        long_pre_en_i = 1'b0;
  logic [15:0] status_o;
  logic        done_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [31:0] tb_crc;
  int dn;

  always #10 clk_i = ~clk_i;

  mii_rx_status u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .rx_dv_i(rx_dv_i), .rx_er_i(rx_er_i),
    .pure_pre_en_i(pure_pre_en_i), .long_pre_en_i(long_pre_en_i),
    .status_o(status_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r = c;
    for (int k = 0; k < 4; k++) r = (r[0] ^ d[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] frame_byte(input int i, input int dkind,
                                            input logic [15:0] tf, input logic [15:0] op);
    int j;
    if (i < 6) begin
      if (dkind == 1) return 8'hFF;
      if (i == 0) return (dkind == 2) ? 8'h01 : 8'h02;
      return 8'(8'h10 + i);
    end
    if (i < 12) return 8'(8'h20 + i);
    if (i == 12) return tf[15:8];
    if (i == 13) return tf[7:0];
    j = i - 14;
    if (tf == 16'h8808 && j == 0) return op[15:8];
    if (tf == 16'h8808 && j == 1) return op[7:0];
    return 8'((j * 7 + 3) & 255);
  endfunction

  task automatic put_nib(input logic [3:0] n, input bit data, input int er_at);
    @(negedge clk_i);
    rx_dv_i = 1'b1;
    rxd_i   = n;
    rx_er_i = data && (dn == er_at);
    if (data) begin
      tb_crc = crc_step(tb_crc, n);
      dn++;
    end
  endtask

  // sends one frame and checks the reported status word against the requirement model
  task automatic run_frame(input string tag, input int npre, input bit impure, input bit sfd,
                           input int dkind, input logic [15:0] tf, input logic [15:0] op,
                           input int npay, input bit bad_fcs, input bit odd,
                           input int er_at, input bit carrier);
    int nb, ndat, tot, wait_n;
    logic [7:0] b;
    logic [31:0] fcs;
    logic [15:0] exp;
    bit drop, seen;
    nb = npay + 18;
    tb_crc = '1;
    dn = 0;
    if (carrier) begin  // R7 carrier event while idle
      @(negedge clk_i); rx_er_i = 1'b1; rxd_i = 4'hE;
      @(negedge clk_i); rx_er_i = 1'b0; rxd_i = 4'h0;
    end
    for (int p = 0; p < npre; p++) put_nib((impure && p == 2) ? 4'h7 : 4'h5, 1'b0, -1);
    if (sfd) begin
      put_nib(4'hD, 1'b0, -1);
      for (int i = 0; i < nb - 4; i++) begin
        b = frame_byte(i, dkind, tf, op);
        put_nib(b[3:0], 1'b1, er_at);
        put_nib(b[7:4], 1'b1, er_at);
      end
      fcs = ~tb_crc;
      if (bad_fcs) fcs[0] = ~fcs[0];
      for (int i = 0; i < 4; i++) begin
        b = fcs[8*i +: 8];
        put_nib(b[3:0], 1'b1, er_at);
        put_nib(b[7:4], 1'b1, er_at);
      end
      if (odd) put_nib(4'hA, 1'b1, er_at);
    end
    @(negedge clk_i);
    rx_dv_i = 1'b0; rx_er_i = 1'b0; rxd_i = 4'h0;

    ndat = sfd ? (2 * nb + (odd ? 1 : 0)) : 0;
    tot  = npre + (sfd ? 1 + ndat : 0);
    drop = (pure_pre_en_i && impure) || (long_pre_en_i && sfd && npre > 23);
    exp  = '0;
    exp[2] = carrier;
    exp[3] = sfd && er_at >= 0 && er_at < ndat;
    if (drop) begin
      exp[12] = 1'b1;  // R2 R3 drop
    end else if (!sfd) begin
      exp[1]  = 1'b1;  // R8
      exp[12] = tot > 12500;
    end else begin
      exp[1]  = ndat < 128;                       // R8
      exp[12] = tot > 12500;                      // R4
      exp[13] = tb_crc != 32'hDEBB20E3;           // R5
      exp[14] = odd;                              // R6
      exp[8]  = dkind == 1;                       // R10
      exp[9]  = dkind == 2;
      exp[4]  = tf <= 16'd1518 && int'(tf) != npay;     // R9
      exp[5]  = tf > 16'd1518 && tf < 16'h0600;
      exp[7]  = tf == 16'h8100;                   // R11
      exp[10] = tf == 16'h8808;
      exp[11] = tf == 16'h8808 && op == 16'h0001;
      exp[6]  = tf == 16'h8808 && op != 16'h0001;
    end
    exp[15] = (exp & 16'h703F) == 16'h0;          // R12

    seen = 1'b0;
    wait_n = 0;
    while (!seen && wait_n < 8) begin
      @(negedge clk_i);
      if (done_o) seen = 1'b1;
      wait_n++;
    end
    chk({tag, " R1 done seen"}, 32'(seen), 32'd1);
    chk({tag, " R1 done on 2nd cycle after dv low"}, 32'(wait_n), 32'd1);
    chk({tag, " status"}, 32'(status_o), 32'(exp));
    @(negedge clk_i);
    chk({tag, " R1 done one cycle"}, 32'(done_o), 32'd0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset done", 32'(done_o), 32'd0);
    chk("R1 reset status", 32'(status_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_frame("R12 good unicast", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R10 broadcast", 15, 0, 1, 1, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R10 multicast", 15, 0, 1, 2, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R11 vlan", 15, 0, 1, 0, 16'h8100, 16'h0, 50, 0, 0, -1, 0);
    run_frame("R11 pause", 15, 0, 1, 1, 16'h8808, 16'h0001, 46, 0, 0, -1, 0);
    run_frame("R11 bad opcode", 15, 0, 1, 0, 16'h8808, 16'h0002, 46, 0, 0, -1, 0);
    run_frame("R9 out of range", 15, 0, 1, 0, 16'd1530, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R9 edge 1518", 15, 0, 1, 0, 16'd1518, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R9 edge 1519", 15, 0, 1, 0, 16'd1519, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R5 bad crc", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 1, 0, -1, 0);
    run_frame("R6 odd nibble", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 1, -1, 0);
    run_frame("R8 short", 15, 0, 1, 0, 16'h0800, 16'h0, 40, 0, 0, -1, 0);
    run_frame("R8 boundary 64 bytes", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R8 no sfd", 15, 0, 0, 0, 16'h0800, 16'h0, 0, 0, 0, -1, 0);
    run_frame("R7 code violation", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, 40, 0);
    run_frame("R7 cv last nibble", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, 127, 0);
    run_frame("R7 carrier", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 1);

    // R9 sweep of length fields, matching and off by one
    for (int n = 46; n < 58; n++) begin
      run_frame("R9 length match", 15, 0, 1, 0, 16'(n), 16'h0, n, 0, 0, -1, 0);
      run_frame("R9 length mismatch", 15, 0, 1, 0, 16'(n + 1), 16'h0, n, 0, 0, -1, 0);
    end

    // R2 impure preamble with check off then on
    run_frame("R2 impure ignored", 15, 1, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    pure_pre_en_i = 1'b1;
    run_frame("R2 impure dropped", 15, 1, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    run_frame("R2 pure kept", 15, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    pure_pre_en_i = 1'b0;

    // R3 preamble length sweep with rejection on and off
    for (int en = 0; en < 2; en++) begin
      long_pre_en_i = en[0];
      for (int p = 1; p <= 26; p++)
        run_frame("R3 preamble length", p, 0, 1, 0, 16'h0800, 16'h0, 46, 0, 0, -1, 0);
    end
    long_pre_en_i = 1'b0;

    // R4 long event boundary
    run_frame("R4 at limit", 15, 0, 1, 0, 16'h0800, 16'h0, 6224, 0, 0, -1, 0);
    run_frame("R4 over limit", 15, 0, 1, 0, 16'h0800, 16'h0, 6225, 0, 0, -1, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule